// File: doc/BRIEF.md
# Framing Byte Error and Loss-of-Frame Monitor

This block watches the receive byte stream of one STS-12 channel. A frame-start strobe marks byte 0 of each frame. The block checks two framing bytes against the expected pattern:

- the final A1 byte, at index 11;
- the leading A2 byte, at index 12.

A frame in which either compared byte is wrong adds one count to a saturating 8-bit error counter. The counter does not count while the framer reports loss of frame. A separate sticky alarm records every loss-of-frame occurrence. That alarm stays set for as long as the framer remains out of frame.

Software reads both values through snapshot pulses. A count snapshot copies the live counter to a read-only holding register and clears the live counter. An alarm snapshot does the same for the sticky alarm. A provisioning enable switches monitoring on or off for the channel. While monitoring is off, the live count and the live alarm are held at zero.

Top module: `frame_align_mon`

## Requirements
- R1: Only the byte at index NUM_A1-1 (default 11) after the frame start is compared with A1_PAT (default 0xF6). Only the byte at index NUM_A1 (default 12) is compared with A2_PAT (default 0x28). All other byte values have no effect on the count. The byte that carries the frame-start strobe has index 0.
- R2: A frame adds exactly one count when either compared byte mismatches, and also when both mismatch.
- R3: The live error counter is 8 bits wide. It holds at 255 and does not wrap.
- R4: Any cycle with the loss-of-frame input high sets the live alarm. The alarm stays set until an alarm snapshot.
- R5: While the loss-of-frame input is high, the live alarm remains set. An alarm snapshot taken during that time does not clear it.
- R6: A count snapshot pulse copies the live count to `err_cnt` on the next clock and clears the live count. If an errored frame is judged in the same cycle, the live count becomes 1. `err_cnt` is 0 after reset.
- R7: An alarm snapshot pulse copies the live alarm to `lof_alarm` on the next clock and clears the live alarm. `lof_alarm` is 0 after reset.
- R8: While `mon_en` is low, no frame is counted and no loss of frame is latched. The live count and the live alarm read as zero.
- R9: A frame whose compared byte arrives while the loss-of-frame input is high is not counted.
- R10: Byte positions advance only on cycles with `byte_vld` high. Idle cycles do not shift the compared positions.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Byte clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mon_en | input | 1 | Monitoring enable for this channel |
| lof_in | input | 1 | Framer loss-of-frame state |
| fstart | input | 1 | High with byte 0 of a frame |
| byte_vld | input | 1 | Byte on `byte_in` is valid |
| byte_in | input | 8 | Received byte |
| cnt_frz | input | 1 | Count snapshot and clear pulse |
| alm_frz | input | 1 | Alarm snapshot and clear pulse |
| err_cnt | output | 8 | Snapshot of the errored-frame count |
| lof_alarm | output | 1 | Snapshot of the loss-of-frame alarm |

## Verification
A count snapshot can land in the very cycle in which the A2 byte of an errored frame is judged. The bench provokes this by raising `cnt_frz` together with byte 12 of a bad frame. It expects the snapshot to show the count as it was before that frame. It expects the live counter to restart at one rather than zero, which a second snapshot reveals. In the same spirit, snapshots taken while loss of frame persists must return a set alarm, and they must leave it set for the next read.

// File: rtl/frame_align_mon_pkg.sv
package frame_align_mon_pkg;

    typedef enum logic [1:0] {
        ROLE_OTHER    = 2'd0,
        ROLE_A1_LAST  = 2'd1,
        ROLE_A2_FIRST = 2'd2
    } byte_role_e;

endpackage

// File: rtl/fam_byte_pos.sv
module fam_byte_pos
    import frame_align_mon_pkg::*;
#(
    parameter int NUM_A1 = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fstart,
    input  logic       byte_vld,
    output byte_role_e role
);
    localparam int POS_W = $clog2(NUM_A1 + 2);
    localparam logic [POS_W-1:0] POS_DONE = POS_W'(NUM_A1 + 1);
    localparam logic [POS_W-1:0] POS_A1   = POS_W'(NUM_A1 - 1);
    localparam logic [POS_W-1:0] POS_A2   = POS_W'(NUM_A1);

    typedef struct packed {
        logic [POS_W-1:0] pos;
    } pos_state_t;

    pos_state_t st_q, st_d;
    logic [POS_W-1:0] idx;

    always_comb begin
        st_d = st_q;
        idx  = fstart ? '0 : st_q.pos;
        role = ROLE_OTHER;
        if (byte_vld) begin
            if (idx == POS_A1)      role = ROLE_A1_LAST;
            else if (idx == POS_A2) role = ROLE_A2_FIRST;
            if (fstart)                   st_d.pos = POS_W'(1);
            else if (st_q.pos < POS_DONE) st_d.pos = st_q.pos + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '{pos: POS_DONE};
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fam_pat_check.sv
module fam_pat_check
    import frame_align_mon_pkg::*;
#(
    parameter logic [7:0] A1_PAT = 8'hF6,
    parameter logic [7:0] A2_PAT = 8'h28
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fstart,
    input  logic       byte_vld,
    input  byte_role_e role,
    input  logic [7:0] byte_in,
    output logic       frame_err
);
    typedef struct packed {
        logic a1_bad;
    } chk_state_t;

    chk_state_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        frame_err = 1'b0;
        if (byte_vld && fstart) st_d.a1_bad = 1'b0;
        case (role)
            ROLE_A1_LAST:  st_d.a1_bad = (byte_in != A1_PAT);
            ROLE_A2_FIRST: begin
                frame_err   = st_q.a1_bad || (byte_in != A2_PAT);
                st_d.a1_bad = 1'b0;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/fam_err_counter.sv
module fam_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             inc,
    input  logic             frz,
    output logic [CNT_W-1:0] live,
    output logic [CNT_W-1:0] held
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    typedef struct packed {
        logic [CNT_W-1:0] live;
        logic [CNT_W-1:0] held;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d = st_q;
        base = frz ? '0 : st_q.live;
        if (frz) st_d.held = st_q.live;
        if (!en)
            st_d.live = '0;
        else if (inc && base != CNT_MAX)
            st_d.live = base + 1'b1;
        else
            st_d.live = base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live = st_q.live;
    assign held = st_q.held;
endmodule

// File: rtl/fam_lof_latch.sv
module fam_lof_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    input  logic lof,
    input  logic frz,
    output logic live,
    output logic held
);
    typedef struct packed {
        logic live;
        logic held;
    } alm_state_t;

    alm_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (frz) st_d.held = st_q.live;
        st_d.live = en && (lof || (st_q.live && !frz));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign live = st_q.live;
    assign held = st_q.held;
endmodule

// File: rtl/frame_align_mon.sv
module frame_align_mon
    import frame_align_mon_pkg::*;
#(
    parameter int         NUM_A1 = 12,
    parameter int         CNT_W  = 8,
    parameter logic [7:0] A1_PAT = 8'hF6,
    parameter logic [7:0] A2_PAT = 8'h28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mon_en,
    input  logic             lof_in,
    input  logic             fstart,
    input  logic             byte_vld,
    input  logic [7:0]       byte_in,
    input  logic             cnt_frz,
    input  logic             alm_frz,
    output logic [CNT_W-1:0] err_cnt,
    output logic             lof_alarm
);
    byte_role_e       role;
    logic             frame_err;
    logic             count_inc;
    logic [CNT_W-1:0] cnt_live;
    logic             alm_live;

    fam_byte_pos #(.NUM_A1(NUM_A1)) u_pos (
        .clk      (clk),
        .rst_n    (rst_n),
        .fstart   (fstart),
        .byte_vld (byte_vld),
        .role     (role)
    );

    fam_pat_check #(.A1_PAT(A1_PAT), .A2_PAT(A2_PAT)) u_chk (
        .clk       (clk),
        .rst_n     (rst_n),
        .fstart    (fstart),
        .byte_vld  (byte_vld),
        .role      (role),
        .byte_in   (byte_in),
        .frame_err (frame_err)
    );

    assign count_inc = frame_err && !lof_in;

    fam_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mon_en),
        .inc   (count_inc),
        .frz   (cnt_frz),
        .live  (cnt_live),
        .held  (err_cnt)
    );

    fam_lof_latch u_alm (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (mon_en),
        .lof   (lof_in),
        .frz   (alm_frz),
        .live  (alm_live),
        .held  (lof_alarm)
    );
endmodule

// File: rtl/frame_align_mon_chk.sv
module frame_align_mon_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             mon_en,
    input logic             lof_in,
    input logic             cnt_frz,
    input logic             alm_frz,
    input logic [CNT_W-1:0] cnt_live,
    input logic             alm_live,
    input logic [CNT_W-1:0] err_cnt,
    input logic             lof_alarm
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && !cnt_frz && cnt_live == CNT_MAX) |=> cnt_live == CNT_MAX);

    assert_single_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && !cnt_frz) |=>
            (cnt_live == $past(cnt_live) || cnt_live == CNT_W'($past(cnt_live) + 1'b1)));

    assert_no_count_in_lof_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && lof_in && !cnt_frz) |=> $stable(cnt_live));

    assert_lof_holds_alarm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && lof_in) |=> alm_live);

    assert_alarm_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mon_en && alm_live && !alm_frz) |=> alm_live);

    assert_cnt_snapshot_R6: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_frz |=> err_cnt == $past(cnt_live));

    assert_alm_snapshot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        alm_frz |=> lof_alarm == $past(alm_live));

    assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_en |=> (cnt_live == '0 && !alm_live));
endmodule

bind frame_align_mon frame_align_mon_chk #(.CNT_W(CNT_W)) u_fam_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mon_en    (mon_en),
    .lof_in    (lof_in),
    .cnt_frz   (cnt_frz),
    .alm_frz   (alm_frz),
    .cnt_live  (cnt_live),
    .alm_live  (alm_live),
    .err_cnt   (err_cnt),
    .lof_alarm (lof_alarm)
);

// File: tb/frame_align_mon_test.sv
`timescale 1ns/1ps
module frame_align_mon_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mon_en = 1'b0;
    logic       lof_in = 1'b0;
    logic       fstart = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_in = 8'h00;
    logic       cnt_frz = 1'b0;
    logic       alm_frz = 1'b0;
    logic [7:0] err_cnt;
    logic       lof_alarm;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    frame_align_mon uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mon_en    (mon_en),
        .lof_in    (lof_in),
        .fstart    (fstart),
        .byte_vld  (byte_vld),
        .byte_in   (byte_in),
        .cnt_frz   (cnt_frz),
        .alm_frz   (alm_frz),
        .err_cnt   (err_cnt),
        .lof_alarm (lof_alarm)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One frame of 26 bytes: index 0..10 carry 0x00, 13..23 carry 0x11, 24..25 carry 0x55.
    task automatic send_frame(input logic [7:0] a1, input logic [7:0] a2,
                              input bit gaps, input bit frz_at_a2);
        for (int i = 0; i < 26; i++) begin
            if (gaps && (i % 3 == 0)) begin
                @(negedge clk);
                fstart = 1'b0; byte_vld = 1'b0; cnt_frz = 1'b0; byte_in = 8'hF6;
            end
            @(negedge clk);
            fstart   = (i == 0);
            byte_vld = 1'b1;
            cnt_frz  = frz_at_a2 && (i == 12);
            byte_in  = (i < 11) ? 8'h00 : (i == 11) ? a1 : (i == 12) ? a2 :
                       (i < 24) ? 8'h11 : 8'h55;
        end
        @(negedge clk);
        fstart = 1'b0; byte_vld = 1'b0; cnt_frz = 1'b0;
    endtask

    task automatic read_cnt(output int v);
        @(negedge clk); cnt_frz = 1'b1;
        @(negedge clk); cnt_frz = 1'b0;
        v = err_cnt;
    endtask

    task automatic read_alm(output int v);
        @(negedge clk); alm_frz = 1'b1;
        @(negedge clk); alm_frz = 1'b0;
        v = lof_alarm;
    endtask

    task automatic t_reset();
        chk("R6 reset count", err_cnt, 0);
        chk("R7 reset alarm", lof_alarm, 0);
    endtask

    task automatic t_good_frames();
        int v;
        for (int k = 0; k < 3; k++) send_frame(8'hF6, 8'h28, k[0], 1'b0);
        read_cnt(v);
        chk("R1 other bytes ignored", v, 0);
    endtask

    task automatic t_bad_bytes();
        int v;
        send_frame(8'hF7, 8'h28, 1'b0, 1'b0);
        read_cnt(v);
        chk("R1 last A1 wrong", v, 1);
        send_frame(8'hF6, 8'h29, 1'b0, 1'b0);
        read_cnt(v);
        chk("R1 first A2 wrong", v, 1);
        send_frame(8'h00, 8'h00, 1'b0, 1'b0);
        read_cnt(v);
        chk("R2 both wrong one count", v, 1);
        send_frame(8'h12, 8'h28, 1'b1, 1'b0);
        send_frame(8'hF6, 8'h28, 1'b1, 1'b0);
        send_frame(8'hF6, 8'h2A, 1'b1, 1'b0);
        send_frame(8'h00, 8'h00, 1'b1, 1'b0);
        read_cnt(v);
        chk("R10 idle cycles keep positions", v, 3);
    endtask

    task automatic t_lof();
        int v;
        lof_in = 1'b1;
        send_frame(8'h00, 8'h00, 1'b0, 1'b0);
        lof_in = 1'b0;
        read_cnt(v);
        chk("R9 no count in LOF", v, 0);
        read_alm(v);
        chk("R4 LOF recorded", v, 1);
        read_alm(v);
        chk("R7 snapshot cleared alarm", v, 0);
        @(negedge clk); lof_in = 1'b1;
        @(negedge clk); lof_in = 1'b0;
        repeat (5) @(negedge clk);
        read_alm(v);
        chk("R4 single-cycle LOF latched", v, 1);
        @(negedge clk); lof_in = 1'b1;
        read_alm(v);
        chk("R5 alarm set in LOF", v, 1);
        read_alm(v);
        chk("R5 clear during LOF ignored", v, 1);
        @(negedge clk); lof_in = 1'b0;
        @(negedge clk);
        read_alm(v);
        chk("R5 alarm kept after LOF", v, 1);
        read_alm(v);
        chk("R7 alarm cleared after LOF", v, 0);
    endtask

    task automatic t_same_cycle();
        int v;
        send_frame(8'h00, 8'h28, 1'b0, 1'b0);
        send_frame(8'h00, 8'h28, 1'b0, 1'b1);
        chk("R6 snapshot before same-cycle count", err_cnt, 1);
        read_cnt(v);
        chk("R6 same-cycle count kept", v, 1);
    endtask

    task automatic t_saturate();
        int v;
        for (int k = 0; k < 260; k++) send_frame(8'hF6, 8'h00, 1'b0, 1'b0);
        read_cnt(v);
        chk("R3 count saturates", v, 255);
        read_cnt(v);
        chk("R6 live count cleared", v, 0);
    endtask

    task automatic t_disabled();
        int v;
        mon_en = 1'b0;
        send_frame(8'h00, 8'h00, 1'b0, 1'b0);
        @(negedge clk); lof_in = 1'b1;
        @(negedge clk); lof_in = 1'b0;
        read_cnt(v);
        chk("R8 no count when disabled", v, 0);
        read_alm(v);
        chk("R8 no alarm when disabled", v, 0);
        mon_en = 1'b1;
        send_frame(8'h00, 8'h00, 1'b0, 1'b0);
        read_cnt(v);
        chk("R8 counting after enable", v, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        t_reset();
        t_good_frames();
        t_bad_bytes();
        t_lof();
        t_same_cycle();
        t_saturate();
        t_disabled();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule